// File: doc/BRIEF.md
# Synchronous Burst Cache Data Store

This block is a synthesizable single-clock burst SRAM that holds the data side of an external-style cache. An access is opened by one of two active-low load strobes. The controller strobe acts in the cycle it is sampled. The processor strobe is honoured only while its chip enable is high, and it runs its access one clock later, which leaves room for a hit check. After a load, an active-low advance strobe steps a two-bit word counter. That counter wraps inside the aligned group of four words, so each following word needs no new address from outside.

Read data comes out of one output register. It appears one clock after the cycle that performs the read, and a valid flag marks it. A parameter picks how write data is timed. In early-write mode the data comes with the address. In late-write mode it comes one clock later, the array update waits for it, and a read of that address in the cycle the data arrives returns the new data.

Top module: `sbram_cache`

## Requirements
- R1: While reset is held and after it is released, `rvalid` is 0 until a read access takes place.
- R2: When `ctl_ld_n` is low, the access at `addr` takes place in that cycle. For a read (`we_n` high), the word is on `rdata` with `rvalid` high in the next cycle.
- R3: In early-write mode (`LATE_WRITE`=0), a controller write (`we_n` low) stores the `wdata` presented in the same cycle as the address.
- R4: When `cpu_ld_n` is low, `cpu_en` is high and `ctl_ld_n` is high, the address and direction are captured and the access takes place in the next cycle, so read data appears two cycles after the strobe. All strobes in that next cycle are ignored.
- R5: `cpu_ld_n` has no effect while `cpu_en` is low.
- R6: When `ctl_ld_n` and `cpu_ld_n` are both low and `cpu_en` is high, the controller strobe wins and the access takes place at once.
- R7: With `adv_n` low and no load, once a burst has been loaded, the low two address bits step by one and wrap from 3 to 0. The upper bits stay the same, and the direction is the one captured at the load.
- R8: A cycle with no load strobe and `adv_n` high performs no access. Advance before any load since reset is ignored.
- R9: In late-write mode (`LATE_WRITE`=1), the data for a write is taken from `wdata` one cycle after its address. Read timing is the same as in early-write mode.
- R10: In late-write mode, a read of the address written in the previous cycle returns the `wdata` presented in the read cycle.
- R11: A write access leaves `rvalid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_ld_n | input | 1 | Controller address-load strobe, active low |
| cpu_ld_n | input | 1 | Processor address-load strobe, active low |
| cpu_en | input | 1 | Enable that gates the processor strobe |
| adv_n | input | 1 | Burst advance strobe, active low |
| we_n | input | 1 | Direction captured at a load: low write, high read |
| addr | input | ADDR_W | External word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rvalid | output | 1 | High when rdata holds the result of a read |

## Verification
The bench drives an early-write and a late-write instance from the same stimulus and checks both against a cycle model. It targets the wrap of a burst started at word 2, where a counter that carried into the upper bits would read from the next group. It covers a processor load followed at once by a controller load, which a design without the busy cycle would run immediately, and both strobes low together, where the wrong priority delays the read by one cycle. It also covers a write followed at once by a read of the same word in late-write mode: without the bypass the read returns stale array contents.

// File: rtl/sbram_pkg.sv
package sbram_pkg;

    // Source of the access performed in the current cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CTL  = 2'd1,
        SRC_CPU  = 2'd2,
        SRC_ADV  = 2'd3
    } acc_src_e;

endpackage

// File: rtl/sbram_seq.sv
module sbram_seq
    import sbram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_ld_n,
    input  logic              cpu_ld_n,
    input  logic              cpu_en,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic               burst_on;
        logic               cpu_pend;
        logic               dir_we;
        logic [HI_W-1:0]    base;
        logic [BURST_W-1:0] cnt;
    } seq_st_t;

    seq_st_t  st_d, st_q;
    acc_src_e src;

    always_comb begin
        st_d      = st_q;
        src       = SRC_NONE;
        acc_valid = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = {st_q.base, st_q.cnt};
        if (st_q.cpu_pend) begin
            src           = SRC_CPU;
            st_d.cpu_pend = 1'b0;
            st_d.burst_on = 1'b1;
        end else if (!ctl_ld_n) begin
            src           = SRC_CTL;
            st_d.base     = addr[ADDR_W-1:BURST_W];
            st_d.cnt      = addr[BURST_W-1:0];
            st_d.dir_we   = !we_n;
            st_d.burst_on = 1'b1;
        end else if (!cpu_ld_n && cpu_en) begin
            st_d.base     = addr[ADDR_W-1:BURST_W];
            st_d.cnt      = addr[BURST_W-1:0];
            st_d.dir_we   = !we_n;
            st_d.cpu_pend = 1'b1;
        end else if (!adv_n && st_q.burst_on) begin
            src      = SRC_ADV;
            st_d.cnt = st_q.cnt + 1'b1;
        end

        case (src)
            SRC_CTL: begin
                acc_valid = 1'b1;
                acc_we    = !we_n;
                acc_addr  = addr;
            end
            SRC_CPU: begin
                acc_valid = 1'b1;
                acc_we    = st_q.dir_we;
                acc_addr  = {st_q.base, st_q.cnt};
            end
            SRC_ADV: begin
                acc_valid = 1'b1;
                acc_we    = st_q.dir_we;
                acc_addr  = {st_q.base, st_d.cnt};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ctl_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_ld_n && !st_q.cpu_pend) |-> (acc_valid && acc_addr == addr && acc_we == !we_n));

    assert_cpu_runs_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ld_n && cpu_en && ctl_ld_n && !st_q.cpu_pend)
        |=> (acc_valid && acc_addr == $past(addr) && acc_we == !$past(we_n)));

    assert_cpu_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_en && ctl_ld_n && adv_n && !st_q.cpu_pend) |-> !acc_valid);

    assert_adv_stays_in_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_n && ctl_ld_n && (cpu_ld_n || !cpu_en) && !st_q.cpu_pend && st_q.burst_on)
        |-> (acc_addr[ADDR_W-1:BURST_W] == st_q.base));

endmodule

// File: rtl/sbram_store.sv
module sbram_store #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter bit LATE_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              lw_v;
        logic [ADDR_W-1:0] lw_a;
    } store_st_t;

    store_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic              bypass;

    generate
        if (LATE_WRITE) begin : g_late
            always_comb begin
                mem_we = st_q.lw_v;
                mem_wa = st_q.lw_a;
            end
        end else begin : g_early
            always_comb begin
                mem_we = acc_valid && acc_we;
                mem_wa = acc_addr;
            end
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        bypass      = LATE_WRITE && st_q.lw_v && (st_q.lw_a == acc_addr);
        st_d.rvalid = acc_valid && !acc_we;
        st_d.lw_v   = acc_valid && acc_we;
        st_d.lw_a   = acc_addr;
        if (acc_valid && !acc_we)
            st_d.rdata = bypass ? wdata : mem[acc_addr];
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

    assert_read_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we) |=> rvalid);

    assert_write_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we) |=> !rvalid);

    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rvalid);

endmodule

// File: rtl/sbram_cache.sv
module sbram_cache #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int BURST_W    = 2,
    parameter bit LATE_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_ld_n,
    input  logic              cpu_ld_n,
    input  logic              cpu_en,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic              acc_valid;
    logic              acc_we;
    logic [ADDR_W-1:0] acc_addr;

    sbram_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_ld_n (ctl_ld_n),
        .cpu_ld_n (cpu_ld_n),
        .cpu_en   (cpu_en),
        .adv_n    (adv_n),
        .we_n     (we_n),
        .addr     (addr),
        .acc_valid(acc_valid),
        .acc_we   (acc_we),
        .acc_addr (acc_addr)
    );

    sbram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATE_WRITE(LATE_WRITE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rvalid);

endmodule

// File: tb/sim_sbram_cache.sv
module sim_sbram_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_ld_n = 1'b1, cpu_ld_n = 1'b1, cpu_en = 1'b0, adv_n = 1'b1, we_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd0, rd1;
    logic        rv0, rv1;

    always #4 clk = ~clk;

    sbram_cache #(.LATE_WRITE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_ld_n(ctl_ld_n), .cpu_ld_n(cpu_ld_n), .cpu_en(cpu_en),
        .adv_n(adv_n), .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rd0), .rvalid(rv0));

    sbram_cache #(.LATE_WRITE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ctl_ld_n(ctl_ld_n), .cpu_ld_n(cpu_ld_n), .cpu_en(cpu_en),
        .adv_n(adv_n), .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rd1), .rvalid(rv1));

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [15:0] m0 [64];
    logic [15:0] m1 [64];
    bit          b_on, b_pend, b_dir;
    logic [5:0]  b_addr;
    bit          lw_v;
    logic [5:0]  lw_a;
    bit          e_rv0, e_rv1;
    logic [15:0] e_rd0, e_rd1;
    string       prev_tag = "R1";
    bit          armed = 1'b0;

    function automatic logic [5:0] step_addr(input logic [5:0] a);
        return {a[5:2], a[1:0] + 2'd1};
    endfunction

    task automatic check_bit(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input string what, input logic [15:0] act,
                              input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input bit c, input bit p, input bit e, input bit v,
                       input bit w, input logic [5:0] a, input logic [15:0] d);
        bit         acc, awe;
        logic [5:0] aa;
        @(negedge clk);
        if (armed) begin
            check_bit(prev_tag, "early rvalid", rv0, e_rv0);
            check_bit(prev_tag, "late rvalid", rv1, e_rv1);
            if (e_rv0) check_word(prev_tag, "early rdata", rd0, e_rd0);
            if (e_rv1) check_word(prev_tag, "late rdata", rd1, e_rd1);
        end
        ctl_ld_n = c; cpu_ld_n = p; cpu_en = e; adv_n = v; we_n = w; addr = a; wdata = d;
        acc = 0; awe = 0; aa = b_addr;
        if (b_pend) begin
            acc = 1; awe = b_dir; aa = b_addr; b_pend = 0; b_on = 1;
        end else if (!c) begin
            acc = 1; awe = !w; aa = a; b_addr = a; b_dir = !w; b_on = 1;
        end else if (!p && e) begin
            b_addr = a; b_dir = !w; b_pend = 1;
        end else if (!v && b_on) begin
            b_addr = step_addr(b_addr); acc = 1; awe = b_dir; aa = b_addr;
        end
        e_rv0 = acc && !awe;
        e_rv1 = acc && !awe;
        if (e_rv0) e_rd0 = m0[aa];
        if (acc && awe) m0[aa] = d;
        if (e_rv1) e_rd1 = (lw_v && lw_a == aa) ? d : m1[aa];
        if (lw_v) m1[lw_a] = d;
        lw_v = acc && awe;
        lw_a = aa;
        prev_tag = tag;
        armed = 1'b1;
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1, 1, 0, 1, 1, 6'd0, 16'($urandom));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        b_on = 0; b_pend = 0; b_dir = 0; b_addr = '0; lw_v = 0; lw_a = '0;
        e_rv0 = 0; e_rv1 = 0; e_rd0 = '0; e_rd1 = '0;
        repeat (3) @(negedge clk);
        check_bit("R1", "early rvalid in reset", rv0, 1'b0);
        check_bit("R1", "late rvalid in reset", rv1, 1'b0);
        rst_n = 1'b1;
        // R8: advance before any load does nothing
        for (int i = 0; i < 3; i++) cyc("R8", 1, 1, 0, 0, 1, 6'd3, 16'hdead);
        idle("R8");
        // fill the array with controller writes (R3, R9)
        for (int i = 0; i < 64; i++) cyc("R3", 0, 1, 0, 1, 0, 6'(i), 16'($urandom));
        idle("R9");
        // R2: single controller read
        cyc("R2", 0, 1, 0, 1, 1, 6'd5, 16'h0);
        idle("R8");
        // R7: read burst starting at word 2 wraps inside group
        cyc("R7", 0, 1, 0, 1, 1, 6'd6, 16'h0);
        for (int i = 0; i < 5; i++) cyc("R7", 1, 1, 0, 0, 1, 6'd0, 16'h0);
        // R3/R7: write burst via advance, then read it back
        cyc("R3", 0, 1, 0, 1, 0, 6'd9, 16'h1111);
        for (int i = 0; i < 3; i++) cyc("R7", 1, 1, 0, 0, 1, 6'd0, 16'(16'h2222 * (i + 1)));
        idle("R9");
        cyc("R7", 0, 1, 0, 1, 1, 6'd8, 16'h0);
        for (int i = 0; i < 3; i++) cyc("R7", 1, 1, 0, 0, 1, 6'd0, 16'h0);
        // R4: processor load, controller load in busy cycle is ignored
        cyc("R4", 1, 0, 1, 1, 1, 6'd20, 16'h0);
        cyc("R4", 0, 1, 0, 1, 1, 6'd30, 16'h0);
        idle("R4");
        idle("R4");
        // R5: processor strobe without enable
        cyc("R5", 1, 0, 0, 1, 1, 6'd21, 16'h0);
        idle("R5");
        // R6: both strobes, controller first
        cyc("R6", 0, 0, 1, 1, 1, 6'd22, 16'h0);
        idle("R6");
        // R10: write then immediate read of same word
        cyc("R10", 0, 1, 0, 1, 0, 6'd40, 16'haaaa);
        cyc("R10", 0, 1, 0, 1, 1, 6'd40, 16'h5a5a);
        idle("R10");
        cyc("R10", 0, 1, 0, 1, 1, 6'd40, 16'h0);
        idle("R11");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit c, p, e, v, w;
            r = int'($urandom_range(0, 99));
            c = !(r < 20);
            p = !(r >= 20 && r < 40);
            e = ($urandom_range(0, 3) != 0);
            v = ($urandom_range(0, 1) == 0);
            w = ($urandom_range(0, 2) != 0);
            cyc("R7", c, p, e, v, w, 6'($urandom), 16'($urandom));
        end
        idle("R8");
        idle("R8");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule